// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the processor's status word: eleven named single-bit flags and a halt flag, packed into a 16-bit word. The instruction decoder hands it one opcode per cycle with a valid strobe and an 8-bit immediate. The block carries out several kinds of flag instruction:

- dedicated opcodes that set or clear exactly one named flag;
- mask operations that set, clear or test the low eight flags;
- restoring the word from a value popped off the stack;
- the halt instruction.

The ALU reports its zero, negative, carry and overflow results through a separate masked update port. A pending explicit flag instruction takes priority over that port.

The stack pointer and memory traffic belong to the surrounding core. The core writes `push_word` to memory when it saves the flags, and it supplies `pop_data` when it restores them. The interrupt controller reads `irq_enable` and `sound_irq_enable`. Branch logic reads the four condition bits directly.

Flag positions in the word:

| Bit | Flag |
|-----|------|
| 0 | zero |
| 1 | negative |
| 2 | carry |
| 3 | overflow |
| 4 to 7 | four user flags |
| 8 | debug |
| 9 | interrupt enable |
| 10 | sound-interrupt enable |
| 11 | halt |
| 12 to 15 | reserved, always zero |

Every change is registered. A change is visible on the outputs in the cycle after the clock edge that captures it.

Top module: `status_flags`

## Requirements
- R1: While rst_n is low the whole flag word is zero. After reset it stays zero until an update is applied.
- R2: A valid opcode in the range 0xA0 to 0xAA sets bit (opcode - 0xA0) of the word. All other bits are unchanged.
- R3: A valid opcode in the range 0xAB to 0xB5 clears bit (opcode - 0xAB). All other bits are unchanged.
- R4: Valid opcode 0xB6 ORs imm_mask into bits 7:0 of the word.
- R5: Valid opcode 0xB7 clears each bit of 7:0 whose imm_mask bit is 1.
- R6: Valid opcode 0xB8 forms T = word[7:0] AND imm_mask from the current word.
  - Bit 0 becomes 1 exactly when T is zero.
  - Bit 2 becomes 1 exactly when T equals imm_mask.
  - No other bit changes.
- R7: push_word always equals the current flag word. Valid opcode 0x0F leaves the word unchanged.
- R8: Valid opcode 0x10 loads bits 10:0 from pop_data[10:0].
  - The halt bit 11 keeps its value.
  - pop_data[15:11] is ignored.
- R9: Valid opcode 0xFF, or halt_req high, sets bit 11. Only reset clears bit 11. `halted` mirrors bit 11.
- R10: When alu_we is high and no explicit flag opcode is present, bit i of the word takes alu_flags[i] for each i in 0..3 where alu_mask[i] is 1. Bit order is zero, negative, carry, overflow.
- R11: An explicit flag opcode (valid 0xA0 to 0xB8, or 0x10) arriving with alu_we discards the ALU update entirely. Opcode 0xFF does not discard it.
- R12: Bits 15:12 always read zero. Opcodes outside the listed ones, and any opcode with op_valid low, change nothing.
- R13: The individual outputs always equal their bits of flag_word:
  - zero_f, neg_f, carry_f and ovf_f are bits 0 to 3;
  - irq_enable is bit 9;
  - sound_irq_enable is bit 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Current instruction opcode |
| imm_mask | input | 8 | Immediate mask for set, clear and test by mask |
| alu_we | input | 1 | ALU condition update strobe |
| alu_flags | input | 4 | ALU results: zero, negative, carry, overflow |
| alu_mask | input | 4 | Selects which ALU results are written |
| pop_data | input | 16 | Word read from the stack for a restore |
| halt_req | input | 1 | External request to set the halt flag |
| flag_word | output | 16 | Complete status word |
| zero_f | output | 1 | Zero flag |
| neg_f | output | 1 | Negative flag |
| carry_f | output | 1 | Carry flag |
| ovf_f | output | 1 | Overflow flag |
| irq_enable | output | 1 | Interrupt enable flag |
| sound_irq_enable | output | 1 | Sound-interrupt enable flag |
| halted | output | 1 | Halt flag |
| push_word | output | 16 | Word to be written to the stack on a save |

## Verification
The whole state of the block is visible on flag_word in every cycle, so a wrong internal value appears on the ports one cycle after the edge that stored it. The bench compares the full word, and the bits brought out separately, after every applied cycle. A corrupted bit is therefore reported at the first sample after it is written. This catches faults such as a wrong bit index in the set and clear decode, a test that writes bits other than zero and carry, or a restore that drops the halt flag. It also catches a lost ALU-versus-opcode priority, which shows as a wrong condition bit in that same cycle.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int WORD_W = 16;
  localparam int NAMED  = 11;
  localparam int MASK_W = 8;
  localparam int ALU_W  = 4;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int H_POS  = NAMED;
  localparam int Z_POS  = 0;
  localparam int N_POS  = 1;
  localparam int C_POS  = 2;
  localparam int V_POS  = 3;
  localparam int I_POS  = 9;
  localparam int S_POS  = 10;

  localparam logic [7:0] OP_SET_BASE = 8'hA0;
  localparam logic [7:0] OP_CLR_BASE = OP_SET_BASE + 8'(NAMED);
  localparam logic [7:0] OP_ORM      = OP_CLR_BASE + 8'(NAMED);
  localparam logic [7:0] OP_ANDN     = OP_ORM + 8'd1;
  localparam logic [7:0] OP_TEST     = OP_ANDN + 8'd1;
  localparam logic [7:0] OP_PUSH     = 8'h0F;
  localparam logic [7:0] OP_POP      = 8'h10;
  localparam logic [7:0] OP_HALT     = 8'hFF;

  typedef logic [WORD_W-1:0] fword_t;
  localparam fword_t LIVE_BITS = fword_t'((1 << (H_POS + 1)) - 1);

  typedef enum logic [2:0] {
    K_NONE, K_SET, K_CLR, K_ORM, K_ANDN, K_TEST, K_POP, K_HALT
  } kind_t;

  function automatic fword_t f_or_mask(fword_t w, logic [MASK_W-1:0] m);
    fword_t r = w;
    r[MASK_W-1:0] = w[MASK_W-1:0] | m;
    return r;
  endfunction

  function automatic fword_t f_andn_mask(fword_t w, logic [MASK_W-1:0] m);
    fword_t r = w;
    r[MASK_W-1:0] = w[MASK_W-1:0] & ~m;
    return r;
  endfunction

  function automatic fword_t f_test(fword_t w, logic [MASK_W-1:0] m);
    fword_t r = w;
    logic [MASK_W-1:0] t = w[MASK_W-1:0] & m;
    r[Z_POS] = (t == '0);
    r[C_POS] = (t == m);
    return r;
  endfunction

  function automatic fword_t f_pop(fword_t w, fword_t p);
    fword_t r = p & LIVE_BITS;
    r[H_POS] = w[H_POS];
    return r;
  endfunction

  function automatic fword_t f_alu(fword_t w, logic [ALU_W-1:0] f, logic [ALU_W-1:0] m);
    fword_t r = w;
    for (int i = 0; i < ALU_W; i++)
      if (m[i]) r[i] = f[i];
    return r;
  endfunction
endpackage

// File: rtl/sf_decode.sv
module sf_decode
  import sf_pkg::*;
(
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  output kind_t            kind,
  output logic [IDX_W-1:0] bit_idx
);
  logic [7:0] set_off, clr_off;
  assign set_off = opcode - OP_SET_BASE;
  assign clr_off = opcode - OP_CLR_BASE;

  always_comb begin
    kind    = K_NONE;
    bit_idx = '0;
    if (op_valid) begin
      if (opcode >= OP_SET_BASE && opcode < OP_CLR_BASE) begin
        kind    = K_SET;
        bit_idx = set_off[IDX_W-1:0];
      end else if (opcode >= OP_CLR_BASE && opcode < OP_ORM) begin
        kind    = K_CLR;
        bit_idx = clr_off[IDX_W-1:0];
      end else if (opcode == OP_ORM)  kind = K_ORM;
      else if (opcode == OP_ANDN)     kind = K_ANDN;
      else if (opcode == OP_TEST)     kind = K_TEST;
      else if (opcode == OP_POP)      kind = K_POP;
      else if (opcode == OP_HALT)     kind = K_HALT;
    end
  end
endmodule

// File: rtl/sf_next.sv
module sf_next
  import sf_pkg::*;
(
  input  fword_t            cur,
  input  kind_t             kind,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [MASK_W-1:0] imm_mask,
  input  logic              alu_we,
  input  logic [ALU_W-1:0]  alu_flags,
  input  logic [ALU_W-1:0]  alu_mask,
  input  fword_t            pop_data,
  input  logic              halt_req,
  output fword_t            nxt,
  output logic              explicit_op
);
  assign explicit_op = (kind != K_NONE) && (kind != K_HALT);

  always_comb begin
    fword_t w;
    w = cur;
    unique case (kind)
      K_SET:   w[bit_idx] = 1'b1;
      K_CLR:   w[bit_idx] = 1'b0;
      K_ORM:   w = f_or_mask(cur, imm_mask);
      K_ANDN:  w = f_andn_mask(cur, imm_mask);
      K_TEST:  w = f_test(cur, imm_mask);
      K_POP:   w = f_pop(cur, pop_data);
      K_HALT:  w[H_POS] = 1'b1;
      default: w = cur;
    endcase
    if (alu_we && !explicit_op) w = f_alu(w, alu_flags, alu_mask);
    if (halt_req) w[H_POS] = 1'b1;
    nxt = w & LIVE_BITS;
  end
endmodule

// File: rtl/status_flags.sv
module status_flags
  import sf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [MASK_W-1:0] imm_mask,
  input  logic              alu_we,
  input  logic [ALU_W-1:0]  alu_flags,
  input  logic [ALU_W-1:0]  alu_mask,
  input  logic [WORD_W-1:0] pop_data,
  input  logic              halt_req,
  output logic [WORD_W-1:0] flag_word,
  output logic              zero_f,
  output logic              neg_f,
  output logic              carry_f,
  output logic              ovf_f,
  output logic              irq_enable,
  output logic              sound_irq_enable,
  output logic              halted,
  output logic [WORD_W-1:0] push_word
);
  kind_t            kind;
  logic [IDX_W-1:0] bit_idx;
  fword_t           state_q, state_d;
  logic             explicit_op;

  sf_decode u_dec (
    .op_valid (op_valid),
    .opcode   (opcode),
    .kind     (kind),
    .bit_idx  (bit_idx)
  );

  sf_next u_nxt (
    .cur         (state_q),
    .kind        (kind),
    .bit_idx     (bit_idx),
    .imm_mask    (imm_mask),
    .alu_we      (alu_we),
    .alu_flags   (alu_flags),
    .alu_mask    (alu_mask),
    .pop_data    (pop_data),
    .halt_req    (halt_req),
    .nxt         (state_d),
    .explicit_op (explicit_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign flag_word        = state_q;
  assign push_word        = state_q;
  assign zero_f           = state_q[Z_POS];
  assign neg_f            = state_q[N_POS];
  assign carry_f          = state_q[C_POS];
  assign ovf_f            = state_q[V_POS];
  assign irq_enable       = state_q[I_POS];
  assign sound_irq_enable = state_q[S_POS];
  assign halted           = state_q[H_POS];

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_word[WORD_W-1:H_POS+1] == '0);

  // R8
  pop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_POP) |=> flag_word[H_POS-1:0] == $past(pop_data[H_POS-1:0]));

  // R6
  test_preserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_TEST && !halt_req) |=>
      (flag_word[WORD_W-1:C_POS+1] == $past(flag_word[WORD_W-1:C_POS+1]) &&
       flag_word[N_POS] == $past(flag_word[N_POS])));

  // R11
  explicit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (explicit_op && alu_we && kind == K_SET && bit_idx == IDX_W'(C_POS)) |=>
      (carry_f && zero_f == $past(zero_f) && neg_f == $past(neg_f) && ovf_f == $past(ovf_f)));

  // R7
  push_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_PUSH && !alu_we && !halt_req) |=> $stable(flag_word));
endmodule

// File: tb/status_flags_test.sv
module status_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  imm_mask = 8'h00;
  logic        alu_we = 1'b0;
  logic [3:0]  alu_flags = 4'h0;
  logic [3:0]  alu_mask = 4'h0;
  logic [15:0] pop_data = 16'h0;
  logic        halt_req = 1'b0;
  logic [15:0] flag_word, push_word;
  logic zero_f, neg_f, carry_f, ovf_f, irq_enable, sound_irq_enable, halted;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [15:0] expw = 16'h0;

  always #4 clk = ~clk;

  status_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .imm_mask(imm_mask), .alu_we(alu_we), .alu_flags(alu_flags),
    .alu_mask(alu_mask), .pop_data(pop_data), .halt_req(halt_req),
    .flag_word(flag_word), .zero_f(zero_f), .neg_f(neg_f), .carry_f(carry_f),
    .ovf_f(ovf_f), .irq_enable(irq_enable), .sound_irq_enable(sound_irq_enable),
    .halted(halted), .push_word(push_word)
  );

  function automatic logic [15:0] model(logic [15:0] s, logic v, logic [7:0] op,
      logic [7:0] m, logic aw, logic [3:0] af, logic [3:0] am,
      logic [15:0] pd, logic hr);
    logic [15:0] r = s;
    logic drop_alu = 1'b0;
    if (v) begin
      if (op >= 8'hA0 && op <= 8'hAA) begin
        r = s | (16'h1 << (op - 8'hA0)); drop_alu = 1'b1;
      end else if (op >= 8'hAB && op <= 8'hB5) begin
        r = s & ~(16'h1 << (op - 8'hAB)); drop_alu = 1'b1;
      end else if (op == 8'hB6) begin
        r = s | {8'h00, m}; drop_alu = 1'b1;
      end else if (op == 8'hB7) begin
        r = s & ~{8'h00, m}; drop_alu = 1'b1;
      end else if (op == 8'hB8) begin
        r[0] = ((s[7:0] & m) == 8'h00);
        r[2] = ((s[7:0] & m) == m);
        drop_alu = 1'b1;
      end else if (op == 8'h10) begin
        r = {4'h0, s[11], pd[10:0]}; drop_alu = 1'b1;
      end else if (op == 8'hFF) begin
        r[11] = 1'b1;
      end
    end
    if (aw && !drop_alu) r[3:0] = (r[3:0] & ~am) | (af & am);
    if (hr) r[11] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(logic v, logic [7:0] op, logic aw, logic hr);
    if (v && aw && ((op >= 8'hA0 && op <= 8'hB8) || op == 8'h10)) return "R11";
    if (v && op >= 8'hA0 && op <= 8'hAA) return "R2";
    if (v && op >= 8'hAB && op <= 8'hB5) return "R3";
    if (v && op == 8'hB6) return "R4";
    if (v && op == 8'hB7) return "R5";
    if (v && op == 8'hB8) return "R6";
    if (v && op == 8'h10) return "R8";
    if ((v && op == 8'hFF) || hr) return "R9";
    if (v && op == 8'h0F) return "R7";
    if (aw) return "R10";
    return "R12";
  endfunction

  task automatic compare(string tag);
    logic [22:0] got, exp;
    got = {flag_word, zero_f, neg_f, carry_f, ovf_f, irq_enable, sound_irq_enable, halted};
    exp = {expw, expw[0], expw[1], expw[2], expw[3], expw[9], expw[10], expw[11]};
    vectors++;
    if (got !== exp || push_word !== expw) begin
      errors++;
      $display("FAIL %s flags got %h (push %h) expected %h", tag, got, push_word, exp);
    end
  endtask

  // Drive at negedge; the posedge between captures; check at the next negedge.
  task automatic step(logic v, logic [7:0] op, logic [7:0] m, logic aw,
      logic [3:0] af, logic [3:0] am, logic [15:0] pd, logic hr);
    string t;
    op_valid = v; opcode = op; imm_mask = m; alu_we = aw;
    alu_flags = af; alu_mask = am; pop_data = pd; halt_req = hr;
    t = tag_of(v, op, aw, hr);
    expw = model(expw, v, op, m, aw, af, am, pd, hr);
    @(negedge clk);
    compare(t);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; alu_we = 1'b0; halt_req = 1'b0;
    @(negedge clk); @(negedge clk);
    expw = 16'h0;
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R2 set each named flag in turn
    for (int k = 0; k < 11; k++) step(1, 8'hA0 + 8'(k), 8'h00, 0, 4'h0, 4'h0, 16'h0, 0);
    // R13 individual outputs with every named flag set
    compare("R13");
    // R3 clear each named flag
    for (int k = 0; k < 11; k++) step(1, 8'hAB + 8'(k), 8'h00, 0, 4'h0, 4'h0, 16'h0, 0);
    // R4 / R5 mask set and clear
    step(1, 8'hB6, 8'hA5, 0, 4'h0, 4'h0, 16'h0, 0);
    step(1, 8'hB7, 8'h21, 0, 4'h0, 4'h0, 16'h0, 0);
    // R6 test: all present, none present, mask zero
    step(1, 8'hB8, 8'h84, 0, 4'h0, 4'h0, 16'h0, 0);
    step(1, 8'hB8, 8'h50, 0, 4'h0, 4'h0, 16'h0, 0);
    step(1, 8'hB8, 8'h00, 0, 4'h0, 4'h0, 16'h0, 0);
    // R10 ALU masked update
    step(0, 8'h00, 8'h00, 1, 4'b1010, 4'b1110, 16'h0, 0);
    // R11 explicit opcode beats ALU
    step(1, 8'hA2, 8'h00, 1, 4'b0101, 4'b1111, 16'h0, 0);
    // R12 invalid strobe and unused opcode
    step(0, 8'hA9, 8'h00, 0, 4'h0, 4'h0, 16'h0, 0);
    step(1, 8'h42, 8'hFF, 0, 4'h0, 4'h0, 16'h0, 0);
    // R8 pop with reserved bits set
    step(1, 8'h10, 8'h00, 0, 4'h0, 4'h0, 16'hFFFF, 0);
    // R7 push leaves state
    step(1, 8'h0F, 8'h00, 0, 4'h0, 4'h0, 16'h0, 0);
    // R9 halt and pop keeps H
    step(1, 8'hFF, 8'h00, 1, 4'hF, 4'h1, 16'h0, 0);
    step(1, 8'h10, 8'h00, 0, 4'h0, 4'h0, 16'h0000, 0);
    do_reset();
    step(0, 8'h00, 8'h00, 0, 4'h0, 4'h0, 16'h0, 1);
    do_reset();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 99);
      if (sel < 70)      op = 8'hA0 + 8'($urandom_range(0, 24));
      else if (sel < 78) op = 8'h0F;
      else if (sel < 88) op = 8'h10;
      else if (sel < 89) op = 8'hFF;
      else               op = 8'($urandom);
      step(($urandom_range(0, 9) != 0), op, 8'($urandom), 1'($urandom),
           4'($urandom), 4'($urandom), 16'($urandom),
           ($urandom_range(0, 299) == 0));
      if (n == 2000) do_reset();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule